// File: doc/BRIEF.md
# Banked Interrupt Input Pending Logic

This block sits at the input side of an interrupt controller. It takes one flat vector of interrupt request lines and turns their level changes into pending bits, one pending vector for each CPU. The low `N_SHARED` lines are shared peripheral sources. Above them, each CPU has its own bank of 32 private lines. Bank `c` occupies line indices `N_SHARED + 32*c` to `N_SHARED + 32*c + 31`.

Interrupt IDs 0..31 are the banked private IDs and exist separately for every CPU. Shared line `k` is interrupt ID `k + 32`. The block keeps the last level seen on every line and acts only on transitions. A rise on a shared line sets pending on the CPUs in that line's target mask. It does so when the line is edge-triggered, or when it is level-triggered and enabled on at least one CPU. A rise on a private line always sets pending for its own CPU only. A fall only updates the recorded level.

A clear port removes pending bits for one ID on a chosen set of CPUs. A set caused by an edge in the same cycle takes precedence over that clear. Priority arbitration, acknowledge handling and the register file are outside this block.

Top module: `irq_bank_pend`

## Requirements
- R1: Synchronous active-high reset clears every recorded line level and every pending bit. `pend_o` reads all zero on the first clock edge after reset is released.
- R2: A 0-to-1 change on shared line k sets pending bit ID k+32 on each CPU c with `tgt_i[k*N_CPU+c]`=1, and on no other CPU. This happens when the line is edge-triggered (`trig_i[k]`=1, 0 means level).
- R3: A rise on a level-triggered shared line k sets pending only when `en_i[c*N_SHARED+k]` is 1 for at least one CPU c. Otherwise no pending bit changes.
- R4: A rise on line `N_SHARED+32*c+j` sets pending bit ID j of CPU c only. It does so whatever the trigger, enable and target inputs hold.
- R5: A line that stays at the same level sets nothing further. A cleared pending bit stays clear while its line is held high.
- R6: A 1-to-0 change on any line leaves all pending bits unchanged.
- R7: With `clr_valid_i`=1, pending bit ID `clr_id_i` is cleared on every CPU c with `clr_mask_i[c]`=1. Other CPUs and other IDs are untouched, and IDs at or above 32+N_SHARED are ignored.
- R8: When an edge sets a pending bit in the same cycle that the clear port targets it, the bit ends up set.
- R9: Rises on several lines in one cycle, shared and private, are all acted on in that cycle.
- R10: A line sampled high at clock edge t shows its pending bit on `pend_o` right after edge t. Before that edge the bit is still clear. Pending bit ID i of CPU c is `pend_o[c*(32+N_SHARED)+i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | N_SHARED+32*N_CPU | Interrupt request lines, shared first, then one 32-line bank per CPU |
| trig_i | input | N_SHARED | Per shared line: 1 edge-triggered, 0 level-triggered |
| en_i | input | N_CPU*N_SHARED | Enable of shared line k for CPU c at bit c*N_SHARED+k |
| tgt_i | input | N_SHARED*N_CPU | Target of shared line k for CPU c at bit k*N_CPU+c |
| clr_valid_i | input | 1 | Pending clear request |
| clr_id_i | input | clog2(32+N_SHARED) | Interrupt ID to clear |
| clr_mask_i | input | N_CPU | CPUs on which the ID is cleared |
| pend_o | output | N_CPU*(32+N_SHARED) | Registered pending bits, CPU c ID i at bit c*(32+N_SHARED)+i |

## Verification
The properties take the request lines and configuration inputs to be synchronous to `clk` and stable across each edge. A "rise" or "fall" is judged against the recorded level, not against the previous clock. The clear-port property assumes that no line rises in the cycle it considers, so that a concurrent set cannot mask the clear. The bench drives every input on the falling edge only. It exercises clears both with and without coincident rises, and with IDs beyond the implemented range.

// File: rtl/irqbp_pkg.sv
package irqbp_pkg;
  // Lines per private CPU bank, which is also the count of banked IDs
  localparam int unsigned BANK_LINES = 32;
  // First interrupt ID used by shared lines
  localparam int unsigned SHARED_BASE = 32;
endpackage

// File: rtl/irqbp_level_track.sv
module irqbp_level_track #(
  parameter int unsigned NL = 96
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NL-1:0] line_i,
  output logic [NL-1:0] lvl_o,
  output logic [NL-1:0] rise_o
);
  logic [NL-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= line_i;
  end

  assign rise_o = line_i & ~lvl_q;
  assign lvl_o  = lvl_q;
endmodule

// File: rtl/irqbp_set_gen.sv
module irqbp_set_gen
  import irqbp_pkg::*;
#(
  parameter int unsigned N_SHARED = 32,
  parameter int unsigned N_CPU    = 2,
  localparam int unsigned NL      = N_SHARED + BANK_LINES * N_CPU,
  localparam int unsigned NUM_IRQ = SHARED_BASE + N_SHARED
) (
  input  logic [NL-1:0]             rise_i,
  input  logic [N_SHARED-1:0]       trig_i,
  input  logic [N_CPU*N_SHARED-1:0] en_i,
  input  logic [N_SHARED*N_CPU-1:0] tgt_i,
  output logic [N_CPU*NUM_IRQ-1:0]  set_o
);
  logic [N_SHARED-1:0] en_any;
  logic [N_SHARED-1:0] sh_fire;

  always_comb begin
    for (int k = 0; k < N_SHARED; k++) begin
      en_any[k] = 1'b0;
      for (int c = 0; c < N_CPU; c++) en_any[k] = en_any[k] | en_i[c*N_SHARED+k];
      sh_fire[k] = rise_i[k] & (trig_i[k] | en_any[k]);
    end
  end

  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    for (genvar j = 0; j < BANK_LINES; j++) begin : g_priv
      // banked lines are edge-only and target their own CPU
      assign set_o[c*NUM_IRQ+j] = rise_i[N_SHARED + BANK_LINES*c + j];
    end
    for (genvar k = 0; k < N_SHARED; k++) begin : g_shared
      assign set_o[c*NUM_IRQ+SHARED_BASE+k] = sh_fire[k] & tgt_i[k*N_CPU+c];
    end
  end
endmodule

// File: rtl/irqbp_pend_bank.sv
module irqbp_pend_bank #(
  parameter int unsigned NUM_IRQ = 64,
  localparam int unsigned ID_W   = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] set_i,
  input  logic               clr_en_i,
  input  logic [ID_W-1:0]    clr_id_i,
  output logic [NUM_IRQ-1:0] pend_o
);
  logic [NUM_IRQ-1:0] clr_vec;
  logic [NUM_IRQ-1:0] pend_q;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_dec
    assign clr_vec[i] = clr_en_i && (clr_id_i == ID_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr_vec) | set_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_bank_pend.sv
module irq_bank_pend
  import irqbp_pkg::*;
#(
  parameter int unsigned N_SHARED = 32,
  parameter int unsigned N_CPU    = 2,
  localparam int unsigned NL      = N_SHARED + BANK_LINES * N_CPU,
  localparam int unsigned NUM_IRQ = SHARED_BASE + N_SHARED,
  localparam int unsigned ID_W    = $clog2(NUM_IRQ)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NL-1:0]             line_i,
  input  logic [N_SHARED-1:0]       trig_i,
  input  logic [N_CPU*N_SHARED-1:0] en_i,
  input  logic [N_SHARED*N_CPU-1:0] tgt_i,
  input  logic                      clr_valid_i,
  input  logic [ID_W-1:0]           clr_id_i,
  input  logic [N_CPU-1:0]          clr_mask_i,
  output logic [N_CPU*NUM_IRQ-1:0]  pend_o
);
  logic [NL-1:0]            lvl_q;
  logic [NL-1:0]            rise;
  logic [N_CPU*NUM_IRQ-1:0] set_vec;

  irqbp_level_track #(.NL(NL)) u_lvl (
    .clk    (clk),
    .rst    (rst),
    .line_i (line_i),
    .lvl_o  (lvl_q),
    .rise_o (rise)
  );

  irqbp_set_gen #(.N_SHARED(N_SHARED), .N_CPU(N_CPU)) u_set (
    .rise_i (rise),
    .trig_i (trig_i),
    .en_i   (en_i),
    .tgt_i  (tgt_i),
    .set_o  (set_vec)
  );

  for (genvar c = 0; c < N_CPU; c++) begin : g_bank
    irqbp_pend_bank #(.NUM_IRQ(NUM_IRQ)) u_pend (
      .clk      (clk),
      .rst      (rst),
      .set_i    (set_vec[c*NUM_IRQ +: NUM_IRQ]),
      .clr_en_i (clr_valid_i & clr_mask_i[c]),
      .clr_id_i (clr_id_i),
      .pend_o   (pend_o[c*NUM_IRQ +: NUM_IRQ])
    );
  end
endmodule

// File: rtl/irq_bank_pend_chk.sv
module irq_bank_pend_chk #(
  parameter int unsigned N_SHARED = 32,
  parameter int unsigned N_CPU    = 2,
  localparam int unsigned NL      = N_SHARED + 32 * N_CPU,
  localparam int unsigned NUM_IRQ = 32 + N_SHARED,
  localparam int unsigned ID_W    = $clog2(NUM_IRQ)
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NL-1:0]             line_i,
  input logic [N_SHARED*N_CPU-1:0] tgt_i,
  input logic                      clr_valid_i,
  input logic [ID_W-1:0]           clr_id_i,
  input logic [N_CPU-1:0]          clr_mask_i,
  input logic [N_CPU*NUM_IRQ-1:0]  pend_o,
  input logic [NL-1:0]             lvl_q,
  input logic [NL-1:0]             rise
);
  // R1
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pend_o == '0));

  for (genvar c = 0; c < N_CPU; c++) begin : g_c
    for (genvar j = 0; j < 32; j++) begin : g_p
      // R4 / R5: a private bit only rises after its own line rose
      p_priv_src_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_o[c*NUM_IRQ+j]) |->
          ($past(line_i[N_SHARED+32*c+j]) && !$past(lvl_q[N_SHARED+32*c+j])));
      // R6
      p_fall_keep_r6: assert property (@(posedge clk) disable iff (rst)
        (lvl_q[N_SHARED+32*c+j] && !line_i[N_SHARED+32*c+j] && !clr_valid_i)
          |=> $stable(pend_o[c*NUM_IRQ+j]));
      // R8
      p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (line_i[N_SHARED+32*c+j] && !lvl_q[N_SHARED+32*c+j] && clr_valid_i &&
         clr_mask_i[c] && (clr_id_i == ID_W'(j))) |=> pend_o[c*NUM_IRQ+j]);
    end
    for (genvar k = 0; k < N_SHARED; k++) begin : g_s
      // R2: a shared bit only rises on a targeted CPU after its line rose
      p_shared_tgt_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_o[c*NUM_IRQ+32+k]) |-> ($past(rise[k]) && $past(tgt_i[k*N_CPU+c])));
    end
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_i
      // R7
      p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (clr_valid_i && clr_mask_i[c] && (clr_id_i == ID_W'(i)) && (rise == '0))
          |=> !pend_o[c*NUM_IRQ+i]);
    end
  end
endmodule

bind irq_bank_pend irq_bank_pend_chk #(.N_SHARED(N_SHARED), .N_CPU(N_CPU)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .line_i      (line_i),
  .tgt_i       (tgt_i),
  .clr_valid_i (clr_valid_i),
  .clr_id_i    (clr_id_i),
  .clr_mask_i  (clr_mask_i),
  .pend_o      (pend_o),
  .lvl_q       (lvl_q),
  .rise        (rise)
);

// File: tb/sim_irq_bank_pend.sv
module sim_irq_bank_pend;
  localparam int NS = 8;
  localparam int NC = 2;
  localparam int NL = NS + 32 * NC;
  localparam int NI = 32 + NS;
  localparam int IW = $clog2(NI);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NL-1:0]    line_i = '0;
  logic [NS-1:0]    trig_i = '0;
  logic [NC*NS-1:0] en_i = '0;
  logic [NS*NC-1:0] tgt_i = '0;
  logic             clr_valid_i = 1'b0;
  logic [IW-1:0]    clr_id_i = '0;
  logic [NC-1:0]    clr_mask_i = '0;
  logic [NC*NI-1:0] pend_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  bit lvl_m [NL];
  bit pm [NC][NI];

  always #10 clk = ~clk;

  irq_bank_pend #(.N_SHARED(NS), .N_CPU(NC)) u0 (
    .clk(clk), .rst(rst), .line_i(line_i), .trig_i(trig_i), .en_i(en_i),
    .tgt_i(tgt_i), .clr_valid_i(clr_valid_i), .clr_id_i(clr_id_i),
    .clr_mask_i(clr_mask_i), .pend_o(pend_o)
  );

  // behavioural reference, updated on every rising edge
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NL; i++) lvl_m[i] = 0;
      for (int c = 0; c < NC; c++) for (int d = 0; d < NI; d++) pm[c][d] = 0;
    end else begin
      if (clr_valid_i && int'(clr_id_i) < NI)
        for (int c = 0; c < NC; c++) if (clr_mask_i[c]) pm[c][clr_id_i] = 0;
      for (int i = 0; i < NL; i++) begin
        if (line_i[i] != lvl_m[i]) begin
          lvl_m[i] = line_i[i];
          if (line_i[i]) begin
            if (i < NS) begin
              bit any_en;
              any_en = 0;
              for (int c = 0; c < NC; c++) if (en_i[c*NS+i]) any_en = 1;
              if (trig_i[i] || any_en)
                for (int c = 0; c < NC; c++) if (tgt_i[i*NC+c]) pm[c][i+32] = 1;
            end else begin
              pm[(i-NS)/32][(i-NS)%32] = 1;
            end
          end
        end
      end
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst && !finished) begin
      int miss;
      miss = -1;
      total++;
      for (int b = 0; b < NC*NI; b++)
        if (miss < 0 && pend_o[b] !== pm[b/NI][b%NI]) miss = b;
      if (miss >= 0) begin
        bad++;
        $display("FAIL R9 model cpu%0d id%0d got %b exp %b", miss/NI, miss%NI,
                 pend_o[miss], pm[miss/NI][miss%NI]);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expect_bit(int c, int id, bit e, string tag);
    total++;
    if (pend_o[c*NI+id] !== e) begin
      bad++;
      $display("FAIL %s cpu%0d id%0d got %b exp %b", tag, c, id, pend_o[c*NI+id], e);
    end
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL R10 watchdog expired got hang exp completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    total++;
    if (pend_o !== '0) begin
      bad++;
      $display("FAIL R1 pend got %h exp 0", pend_o);
    end

    // R2: edge shared line 2 targets CPU1 only
    trig_i[2] = 1; tgt_i[2*NC+1] = 1; line_i[2] = 1;
    tick();
    expect_bit(1, 34, 1, "R2");
    expect_bit(0, 34, 0, "R2");

    // R3: level line 3, no enable, then enabled on CPU0
    tgt_i[3*NC+0] = 1; tgt_i[3*NC+1] = 1; line_i[3] = 1;
    tick();
    expect_bit(0, 35, 0, "R3");
    expect_bit(1, 35, 0, "R3");
    line_i[3] = 0;
    tick();
    en_i[0*NS+3] = 1; line_i[3] = 1;
    tick();
    expect_bit(0, 35, 1, "R3");
    expect_bit(1, 35, 1, "R3");

    // R4: private CPU1 id5
    line_i[NS+32+5] = 1;
    tick();
    expect_bit(1, 5, 1, "R4");
    expect_bit(0, 5, 0, "R4");

    // R7 then R5: clear while the line stays high
    clr_valid_i = 1; clr_id_i = 5; clr_mask_i = 2'b10;
    tick();
    clr_valid_i = 0;
    expect_bit(1, 5, 0, "R7");
    repeat (3) tick();
    expect_bit(1, 5, 0, "R5");

    // R7: mask selects CPU0 only
    clr_valid_i = 1; clr_id_i = 35; clr_mask_i = 2'b01;
    tick();
    clr_valid_i = 0;
    expect_bit(0, 35, 0, "R7");
    expect_bit(1, 35, 1, "R7");

    // R6: falling edge keeps pending
    line_i[2] = 0;
    tick();
    expect_bit(1, 34, 1, "R6");

    // R8: set beats a simultaneous clear
    line_i[NS+5] = 1; clr_valid_i = 1; clr_id_i = 5; clr_mask_i = 2'b11;
    tick();
    clr_valid_i = 0;
    expect_bit(0, 5, 1, "R8");
    expect_bit(1, 5, 0, "R7");

    // R9: several rises in one cycle
    trig_i[0] = 1; tgt_i[0*NC+0] = 1; tgt_i[0*NC+1] = 1;
    trig_i[1] = 1; tgt_i[1*NC+0] = 1;
    line_i[0] = 1; line_i[1] = 1; line_i[NS+7] = 1; line_i[NS+32+7] = 1;
    tick();
    expect_bit(0, 32, 1, "R9");
    expect_bit(1, 32, 1, "R9");
    expect_bit(0, 33, 1, "R9");
    expect_bit(1, 33, 0, "R9");
    expect_bit(0, 7, 1, "R9");
    expect_bit(1, 7, 1, "R9");

    // R10: latency of one edge
    line_i[NS+9] = 1;
    #2;
    expect_bit(0, 9, 0, "R10");
    tick();
    expect_bit(0, 9, 1, "R10");

    // mixed random traffic, checked every cycle against the reference
    for (int n = 0; n < 600; n++) begin
      if (n % 50 == 0) begin
        trig_i = NS'($urandom);
        en_i = (NC*NS)'($urandom);
        tgt_i = (NS*NC)'($urandom);
      end
      for (int i = 0; i < NL; i++) if ($urandom_range(7) == 0) line_i[i] = ~line_i[i];
      clr_valid_i = ($urandom_range(3) == 0);
      clr_id_i = ($urandom_range(9) == 0) ? IW'(NI + 3) : IW'($urandom_range(NI-1));
      clr_mask_i = NC'($urandom);
      tick();
    end
    clr_valid_i = 0;
    tick();
    finish_run();
  end
endmodule